// File: doc/BRIEF.md
# Endpoint DMA Permission Register Block

This block decides which of the device controller's endpoints may move data by DMA. Software sets permission bits by writing ones to an enable register. It clears them by writing ones to a separate disable register. Zeros written to either register leave the bits alone, so no read-modify-write is needed. The current permission vector can be read back at its own offset. It also drives the DMA engine directly through `ep_dma_en`.

The DMA engine reports, per endpoint, a transfer in progress, a completion strobe and an error. A disable that lands while that endpoint is busy is held pending, and the bit drops once the transfer ends. An error clears the bit at once. Every write to the disable register also clears a proceed flag, which the DMA engine sets with a strobe. A read-only summary word shows whether any end-of-transfer bit or any descriptor-request bit is set.

Top module: `ep_dma_gate`

## Requirements
- R1: Writing offset 0x288 with a 1 in bit i (2 ≤ i < NUM_EP) sets `ep_dma_en[i]` on the next clock edge; bits written as 0 leave the matching enable unchanged.
- R2: Endpoints 0 and 1 (control OUT and control IN) can never be enabled; `ep_dma_en[1:0]` and bits 1:0 of the status read are always 0.
- R3: Writing offset 0x28C with a 1 in bit i clears `ep_dma_en[i]` on the next edge when that endpoint is not busy; bits written as 0 leave the matching enable unchanged.
- R4: Any write to offset 0x28C, even of all zeros, clears `proceed` on the next edge, and this takes priority over a `proceed_set` strobe in the same cycle.
- R5: A disable of an enabled endpoint whose `xfer_busy` bit is 1 keeps the enable at 1 until `xfer_busy` falls or `xfer_done` pulses for it; the bit clears on the edge after that.
- R6: An `xfer_err` pulse on an endpoint clears its enable on the next edge and drops any pending disable; it takes priority over an enable write in the same cycle.
- R7: A read of offset 0x290 returns bit 0 = OR of `eot_status`, bit 1 = OR of `desc_req_status`, bits 31:2 = 0.
- R8: After reset, `ep_dma_en`, `proceed` and `bus_rdata` are all 0.
- R9: A read of offset 0x284 returns `ep_dma_en` zero-extended; reads of 0x288, 0x28C or any unmapped offset return 0; read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R10: An enable write to an endpoint with a pending disable cancels the pending disable; the enable stays 1 after the transfer ends.
- R11: A `proceed_set` pulse with no disable write in the same cycle sets `proceed` on the next edge, and it stays 1 until a disable write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| xfer_busy | input | NUM_EP | Per-endpoint transfer in progress |
| xfer_done | input | NUM_EP | Per-endpoint transfer completion strobe |
| xfer_err | input | NUM_EP | Per-endpoint error strobe |
| eot_status | input | NUM_EP | End-of-transfer status bits |
| desc_req_status | input | NUM_EP | New-descriptor-request status bits |
| proceed_set | input | 1 | Strobe that sets the proceed flag |
| ep_dma_en | output | NUM_EP | Per-endpoint DMA permission |
| proceed | output | 1 | Proceed flag |

## Verification
Assertions check on every cycle that an error clears its endpoint and that a busy endpoint holds its enable through a disable. They also check that an enable write takes effect, that a disable write clears the proceed flag, and that the summary and write-only reads return the right words. Some behaviour only shows up in the bench's scenarios. This covers the sweep proving that the two control endpoints stay locked at every bit position, the delayed drop once busy falls or done pulses, and the cancelling of a pending disable by a later enable. The summary OR is swept one bit at a time.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int unsigned REG_AW   = 12;
  localparam logic [REG_AW-1:0] OFS_STAT = 12'h284;
  localparam logic [REG_AW-1:0] OFS_ENA  = 12'h288;
  localparam logic [REG_AW-1:0] OFS_DIS  = 12'h28C;
  localparam logic [REG_AW-1:0] OFS_SUM  = 12'h290;
  localparam int unsigned NUM_CTRL_EP = 2;
endpackage

// File: rtl/ep_dma_slot.sv
module ep_dma_slot #(
  parameter bit LOCKED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_hit,
  input  logic clr_hit,
  input  logic busy,
  input  logic done,
  input  logic err,
  output logic en
);
  logic en_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (err) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_hit) begin
      if (busy && en_q) begin
        pend_q <= 1'b1;
      end else begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (set_hit) begin
      en_q   <= !LOCKED;
      pend_q <= 1'b0;
    end else if (pend_q && (done || !busy)) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  assign en = en_q;

  assert_err_clears_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> !en_q);
  assert_set_takes_R1: assert property (@(posedge clk) disable iff (rst)
    (set_hit && !clr_hit && !err) |=> (en_q == !LOCKED));
  assert_busy_defers_R5: assert property (@(posedge clk) disable iff (rst)
    (en_q && busy && clr_hit && !err) |=> en_q);
endmodule

// File: rtl/ep_dma_regif.sv
module ep_dma_regif
  import ep_dma_pkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned ADDR_W = REG_AW,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_EP-1:0] en_vec,
  input  logic [NUM_EP-1:0] eot_status,
  input  logic [NUM_EP-1:0] desc_req_status,
  output logic [NUM_EP-1:0] set_mask,
  output logic [NUM_EP-1:0] clr_mask,
  output logic              dis_write,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(OFS_SUM);

  logic ena_write;
  assign ena_write = bus_wr && (bus_addr == A_ENA);
  assign dis_write = bus_wr && (bus_addr == A_DIS);
  assign set_mask  = ena_write ? bus_wdata[NUM_EP-1:0] : '0;
  assign clr_mask  = dis_write ? bus_wdata[NUM_EP-1:0] : '0;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_STAT) rd_mux = DATA_W'(en_vec);
    else if (bus_addr == A_SUM) rd_mux = DATA_W'({|desc_req_status, |eot_status});
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_summary_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_SUM) |=>
      (bus_rdata == DATA_W'({$past(|desc_req_status), $past(|eot_status)})));
  assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_ENA || bus_addr == A_DIS)) |=> (bus_rdata == '0));
endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate
  import ep_dma_pkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned ADDR_W = REG_AW,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EP-1:0] xfer_busy,
  input  logic [NUM_EP-1:0] xfer_done,
  input  logic [NUM_EP-1:0] xfer_err,
  input  logic [NUM_EP-1:0] eot_status,
  input  logic [NUM_EP-1:0] desc_req_status,
  input  logic              proceed_set,
  output logic [NUM_EP-1:0] ep_dma_en,
  output logic              proceed
);
  logic [NUM_EP-1:0] set_mask;
  logic [NUM_EP-1:0] clr_mask;
  logic              dis_write;

  ep_dma_regif #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_vec(ep_dma_en),
    .eot_status(eot_status), .desc_req_status(desc_req_status),
    .set_mask(set_mask), .clr_mask(clr_mask), .dis_write(dis_write),
    .bus_rdata(bus_rdata)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_dma_slot #(.LOCKED(g < NUM_CTRL_EP)) u_slot (
      .clk(clk), .rst(rst),
      .set_hit(set_mask[g]), .clr_hit(clr_mask[g]),
      .busy(xfer_busy[g]), .done(xfer_done[g]), .err(xfer_err[g]),
      .en(ep_dma_en[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)              proceed <= 1'b0;
    else if (dis_write)   proceed <= 1'b0;
    else if (proceed_set) proceed <= 1'b1;
  end

  assert_dis_clears_proceed_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIS)) |=> !proceed);
  assert_proceed_sets_R11: assert property (@(posedge clk) disable iff (rst)
    (proceed_set && !(bus_wr && bus_addr == ADDR_W'(OFS_DIS))) |=> proceed);
endmodule

// File: tb/test_ep_dma_gate.sv
module test_ep_dma_gate;
  localparam int unsigned NUM_EP = 32;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [11:0] A_STAT = 12'h284, A_ENA = 12'h288, A_DIS = 12'h28C, A_SUM = 12'h290;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_EP-1:0] xfer_busy = '0, xfer_done = '0, xfer_err = '0;
  logic [NUM_EP-1:0] eot_status = '0, desc_req_status = '0;
  logic proceed_set = 1'b0;
  logic [NUM_EP-1:0] ep_dma_en;
  logic proceed;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_dma_gate #(.NUM_EP(NUM_EP)) i_ep_dma_gate (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .eot_status(eot_status),
    .desc_req_status(desc_req_status), .proceed_set(proceed_set),
    .ep_dma_en(ep_dma_en), .proceed(proceed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NUM_EP-1:0] exp_en;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk("R8 en", ep_dma_en, '0);
    chk("R8 proceed", {31'b0, proceed}, 0);
    chk("R8 rdata", bus_rdata, 0);

    // R1 / R2 / R3 sweep over every endpoint
    exp_en = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      wr(A_ENA, 32'(1) << i);
      if (i >= 2) exp_en[i] = 1'b1;
      chk(i < 2 ? "R2 locked" : "R1 set", ep_dma_en, exp_en);
    end
    rd(A_STAT, d);
    chk("R9 status read", d, exp_en);
    chk("R2 status bits", {30'b0, d[1:0]}, 0);
    wr(A_ENA, 32'h0);
    chk("R1 zero write", ep_dma_en, exp_en);
    wr(A_DIS, 32'h0);
    chk("R3 zero write", ep_dma_en, exp_en);
    for (int i = 0; i < NUM_EP; i++) begin
      wr(A_DIS, 32'(1) << i);
      exp_en[i] = 1'b0;
      chk("R3 clear", ep_dma_en, exp_en);
    end
    wr(A_ENA, 32'hFFFF_FFFF);
    chk("R2 all ones", ep_dma_en, 32'hFFFF_FFFC);
    rd(A_ENA, d);  chk("R9 enable reads 0", d, 0);
    rd(A_DIS, d);  chk("R9 disable reads 0", d, 0);
    rd(12'h100, d); chk("R9 unmapped reads 0", d, 0);

    // R11 / R4 proceed flag
    @(negedge clk); proceed_set = 1'b1;
    @(negedge clk); proceed_set = 1'b0;
    chk("R11 set", {31'b0, proceed}, 1);
    repeat (3) @(negedge clk);
    chk("R11 held", {31'b0, proceed}, 1);
    wr(A_DIS, 32'h0);
    chk("R4 zero write clears", {31'b0, proceed}, 0);
    chk("R4 no enable change", ep_dma_en, 32'hFFFF_FFFC);
    @(negedge clk); proceed_set = 1'b1; bus_wr = 1'b1; bus_addr = A_DIS; bus_wdata = 0;
    @(negedge clk); proceed_set = 1'b0; bus_wr = 1'b0;
    chk("R4 beats set", {31'b0, proceed}, 0);

    // R5 deferred disable ended by busy falling
    @(negedge clk); xfer_busy[5] = 1'b1;
    wr(A_DIS, 32'(1) << 5);
    chk("R5 held while busy", {31'b0, ep_dma_en[5]}, 1);
    repeat (2) @(negedge clk);
    chk("R5 still held", {31'b0, ep_dma_en[5]}, 1);
    xfer_busy[5] = 1'b0;
    @(negedge clk);
    chk("R5 drops after busy", {31'b0, ep_dma_en[5]}, 0);
    // R5 ended by done strobe
    @(negedge clk); xfer_busy[8] = 1'b1;
    wr(A_DIS, 32'(1) << 8);
    chk("R5 held for done", {31'b0, ep_dma_en[8]}, 1);
    xfer_done[8] = 1'b1;
    @(negedge clk); xfer_done[8] = 1'b0;
    chk("R5 drops on done", {31'b0, ep_dma_en[8]}, 0);
    xfer_busy[8] = 1'b0;

    // R10 enable cancels pending disable
    @(negedge clk); xfer_busy[6] = 1'b1;
    wr(A_DIS, 32'(1) << 6);
    wr(A_ENA, 32'(1) << 6);
    xfer_busy[6] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 cancel", {31'b0, ep_dma_en[6]}, 1);

    // R6 error clears, and beats enable in the same cycle
    @(negedge clk); xfer_err[7] = 1'b1;
    @(negedge clk); xfer_err[7] = 1'b0;
    chk("R6 error clears", {31'b0, ep_dma_en[7]}, 0);
    @(negedge clk); xfer_err[7] = 1'b1; bus_wr = 1'b1; bus_addr = A_ENA; bus_wdata = 32'(1) << 7;
    @(negedge clk); xfer_err[7] = 1'b0; bus_wr = 1'b0;
    chk("R6 error beats enable", {31'b0, ep_dma_en[7]}, 0);

    // R7 summary sweep
    rd(A_SUM, d); chk("R7 idle", d, 0);
    for (int i = 0; i < NUM_EP; i++) begin
      eot_status = '0; desc_req_status = '0; eot_status[i] = 1'b1;
      rd(A_SUM, d); chk("R7 eot", d, 32'h1);
      eot_status = '0; desc_req_status[i] = 1'b1;
      rd(A_SUM, d); chk("R7 desc req", d, 32'h2);
    end
    eot_status = '1; desc_req_status = '1;
    rd(A_SUM, d); chk("R7 both", d, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule